// File: doc/BRIEF.md
# Dual-Phase Blink Output Controller

This block holds the output pattern state of a 17-output open-drain port expander and decides which of two stored patterns drives the pins. Each pattern set (phase 0 and phase 1) holds sixteen output levels in two byte registers, plus one bit for output 16 kept in the configuration byte. A software flip bit and an external blink pin are combined by exclusive-OR to pick the active set, but only while the blink enable bit is set. With blink disabled, phase 0 alone drives the pins.

A simple register port writes the pattern bytes and the configuration byte, and reads them back. Reads return the stored values and never the sensed pin levels. The blink pin is synchronised by two flops before it is used. Its synchronised level can be read as a status bit, so that the pin can also serve as a plain input. An active-low asynchronous reset returns every output to high impedance and disables blinking.

Top module: `blink_out_ctrl`

## Requirements
- R1: After reset, all four pattern bytes read 0xFF and the configuration byte reads 0x0C (both output-16 bits set, enable, flip and PWM-mode clear, status 0). `pull_low` is all zeros.
- R2: A write with `wr_en` high stores `wdata` at the next rising edge. Addresses: 0 = phase-0 outputs 0..7, 1 = phase-0 outputs 8..15, 2 = phase-1 outputs 0..7, 3 = phase-1 outputs 8..15, 4 = configuration. Each read returns the stored byte, whatever the state of the pins.
- R3: With the enable bit (configuration bit 0) clear, the flip bit and the blink pin have no effect, and the phase-0 pattern drives all 17 outputs.
- R4: With the enable bit set, the active set is phase 1 exactly when the flip bit (configuration bit 1) differs from the synchronised blink pin level. Otherwise it is phase 0.
- R5: Output bit n of the active set maps to `pull_low[n]`. A stored 1 gives `pull_low[n]`=0 (high impedance) and a stored 0 gives `pull_low[n]`=1. The low byte of a set feeds outputs 0..7 and the high byte feeds outputs 8..15.
- R6: Output 16 takes configuration bit 2 in phase 0 and configuration bit 3 in phase 1.
- R7: Configuration bit 4 is stored and read back with no effect on the outputs. Bit 7 reads the synchronised blink pin level and ignores writes. Bits 5 and 6 read 0.
- R8: A change on `blink_pin` shows in the status bit and in the phase choice after exactly two rising edges.
- R9: Addresses 5 to 7 read 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| blink_pin | input | 1 | External blink input, asynchronous |
| pull_low | output | 17 | 1 = drive pin low, 0 = high impedance |

## Verification
A register write is due on `pull_low` and `rdata` from the rising edge that samples it. A `blink_pin` change is due two rising edges later. Reads are combinational on `addr`, with no added delay. The bench drives inputs 2 ns after each rising edge. It compares both outputs against a behavioural model at every falling edge, so each result is checked in the first cycle it is due. The model keeps a short queue of sampled pin levels, which makes the two-edge latency an explicit expectation.

// File: rtl/blink_out_ctrl.sv
module blink_out_ctrl #(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          blink_pin,
  output logic [2*DW:0] pull_low
);

  localparam int NOUT = 2 * DW + 1;

  logic [DW-1:0] ph0_lo, ph0_hi, ph1_lo, ph1_hi;
  logic          en_q, flip_q, o16_ph0, o16_ph1, pwm_q;
  logic [1:0]    sync_q;
  logic          blink_s, use_ph1;
  logic [NOUT-1:0] level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph0_lo  <= '1;
      ph0_hi  <= '1;
      ph1_lo  <= '1;
      ph1_hi  <= '1;
      en_q    <= 1'b0;
      flip_q  <= 1'b0;
      o16_ph0 <= 1'b1;
      o16_ph1 <= 1'b1;
      pwm_q   <= 1'b0;
    end else if (wr_en) begin
      case (addr)
        AW'(0): ph0_lo <= wdata;
        AW'(1): ph0_hi <= wdata;
        AW'(2): ph1_lo <= wdata;
        AW'(3): ph1_hi <= wdata;
        AW'(4): begin
          en_q    <= wdata[0];
          flip_q  <= wdata[1];
          o16_ph0 <= wdata[2];
          o16_ph1 <= wdata[3];
          pwm_q   <= wdata[4];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], blink_pin};
  end

  assign blink_s  = sync_q[1];
  assign use_ph1  = en_q & (flip_q ^ blink_s);
  assign level    = use_ph1 ? {o16_ph1, ph1_hi, ph1_lo} : {o16_ph0, ph0_hi, ph0_lo};
  assign pull_low = ~level;

  always_comb begin
    rdata = '0;
    case (addr)
      AW'(0): rdata = ph0_lo;
      AW'(1): rdata = ph0_hi;
      AW'(2): rdata = ph1_lo;
      AW'(3): rdata = ph1_hi;
      AW'(4): rdata = {blink_s, 2'b00, pwm_q, o16_ph1, o16_ph0, flip_q, en_q};
      default: rdata = '0;
    endcase
  end

endmodule

module blink_out_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [2:0]  addr,
  input logic [7:0]  rdata,
  input logic        blink_pin,
  input logic [16:0] pull_low,
  input logic        en_q,
  input logic [1:0]  sync_q
);

  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cyc <= 2'd0;
    else if (cyc != 3) cyc <= cyc + 2'd1;
  end

  AST_RESET_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 0) |-> (pull_low == 17'h0)); // R1

  AST_OFF_IGNORES_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !en_q) |=> $stable(pull_low)); // R3

  AST_HOLD_WHEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && sync_q[0] == sync_q[1]) |=> $stable(pull_low)); // R4

  AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2) |-> (sync_q[1] == $past(blink_pin, 2))); // R8

  AST_CFG_GAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 3'd4) |-> (rdata[6:5] == 2'b00)); // R7

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr > 3'd4) |-> (rdata == 8'h00)); // R9

endmodule

bind blink_out_ctrl blink_out_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .rdata(rdata),
  .blink_pin(blink_pin), .pull_low(pull_low), .en_q(en_q), .sync_q(sync_q)
);

// File: tb/blink_out_ctrl_tb.sv
module blink_out_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [7:0]  wdata = 8'h00;
  logic        blink_pin = 1'b0;
  logic [7:0]  rdata;
  logic [16:0] pull_low;

  int checks = 0;
  int fails  = 0;
  string tag = "R1";
  bit done = 1'b0;

  always #4 clk = ~clk;

  blink_out_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .blink_pin(blink_pin), .pull_low(pull_low)
  );

  // behavioural model
  logic [7:0] m_reg [5];
  bit pin_q[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) m_reg[i] = 8'hFF;
      m_reg[4] = 8'h0C;
      pin_q = {};
    end else begin
      if (wr_en && addr < 3'd5) m_reg[addr] = (addr == 3'd4) ? (wdata & 8'h1F) : wdata;
      pin_q.push_front(blink_pin);
      if (pin_q.size() > 2) void'(pin_q.pop_back());
    end
  end

  function automatic bit m_sync();
    return (pin_q.size() == 2) ? pin_q[1] : 1'b0;
  endfunction

  function automatic logic [16:0] m_pull();
    bit phase1;
    logic [16:0] drv;
    phase1 = m_reg[4][0] && (m_reg[4][1] != m_sync());
    for (int n = 0; n < 17; n++) begin
      bit lvl;
      if (n == 16)     lvl = phase1 ? m_reg[4][3] : m_reg[4][2];
      else if (n < 8)  lvl = phase1 ? m_reg[2][n] : m_reg[0][n];
      else             lvl = phase1 ? m_reg[3][n-8] : m_reg[1][n-8];
      drv[n] = !lvl;
    end
    return drv;
  endfunction

  function automatic logic [7:0] m_read();
    if (addr < 3'd4)  return m_reg[addr];
    if (addr == 3'd4) return m_reg[4] | {m_sync(), 7'b0};
    return 8'h00;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks += 2;
      if (pull_low !== m_pull()) begin
        fails++;
        $display("FAIL %s pull_low act=%h exp=%h", tag, pull_low, m_pull());
      end
      if (rdata !== m_read()) begin
        fails++;
        $display("FAIL %s rdata addr=%0d act=%h exp=%h", tag, addr, rdata, m_read());
      end
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd_all();
    for (int a = 0; a < 8; a++) begin
      addr = 3'(a);
      step();
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    // R1: reset values on every address
    tag = "R1"; rd_all();
    // R2 / R5: pattern write and readback, bit mapping
    tag = "R2"; wr(3'd0, 8'hA5); wr(3'd1, 8'h3C); wr(3'd2, 8'h0F); wr(3'd3, 8'hF0);
    rd_all();
    tag = "R5"; wr(3'd0, 8'h01); wr(3'd1, 8'h80); step(2);
    // R9: unmapped writes ignored
    tag = "R9"; wr(3'd5, 8'h00); wr(3'd6, 8'h55); wr(3'd7, 8'h12); rd_all();
    // R6: output 16 per phase
    tag = "R6"; wr(3'd4, 8'h08); step(); wr(3'd4, 8'h05); step(); wr(3'd4, 8'h09); step();
    // R3: enable clear, flip and pin ignored
    tag = "R3"; wr(3'd4, 8'h0A); addr = 3'd4;
    blink_pin = 1'b1; step(3); blink_pin = 1'b0; step(3);
    // R4: all flip/pin combinations with enable set
    tag = "R4";
    for (int f = 0; f < 2; f++)
      for (int p = 0; p < 2; p++) begin
        blink_pin = p[0];
        wr(3'd4, {6'b0, f[0], 1'b1} | 8'h04);
        step(3);
      end
    // R8: two-edge latency of the pin
    tag = "R8"; wr(3'd4, 8'h05); addr = 3'd4;
    blink_pin = 1'b1; step(); blink_pin = 1'b0; step(); blink_pin = 1'b1; step(4);
    // R7: config bits 4..7 behaviour
    tag = "R7"; wr(3'd4, 8'hFF); addr = 3'd4; step(2); wr(3'd4, 8'h10); step(2);
    // mixed traffic
    tag = "R4";
    for (int i = 0; i < 400; i++) begin
      blink_pin = 1'($urandom);
      if ($urandom % 3 == 0) wr(3'($urandom), 8'($urandom));
      else begin addr = 3'($urandom); step(); end
    end
    // R1: asynchronous reset mid-run
    tag = "R1"; rst_n = 1'b0; step(); rst_n = 1'b1; rd_all();
    finish_run();
  end

endmodule